// File: doc/BRIEF.md
# Periodic Wakeup Down-Counter

This block produces periodic wakeup events for an always-on timekeeping domain. Software programs a reload value, a clock-select code, an enable bit and an interrupt-enable bit. While the block is enabled, a down-counter runs on the selected tick and raises a sticky wakeup flag each time it expires. The counter then reloads itself. The interrupt output follows the flag when interrupts are enabled.

The tick comes from one of two places. Four select codes divide the block clock by a power of two. The other codes take a slow tick input that is already synchronous to the clock. When the top select bit is set, the counter is 17 bits wide and the middle select bit serves as reload bit 16. This makes long periods possible on the slow tick.

A ready output guards the reload register. Writes to the reload value are accepted only while ready is high. Ready falls on the first tick after the block is enabled, and it rises again on the first tick after the block is disabled. A forbidden setting (the fastest divider with a zero reload) is reported on a fault output, and while the fault is present the counter is frozen.

Top module: `wakeup_timer`

## Requirements
- R1: After reset, reload_q is 0xFFFF, wr_ready is 1, and wake_flag, wake_irq and cfg_fault are all 0.
- R2: While enabled, the flag is set once every (full+1) selected ticks, and the counter reloads automatically after each expiry.
- R3: Clock-select codes 000, 001, 010 and 011 give a tick every 16, 8, 4 and 2 clock cycles. Any code with bit 2 set uses the sec_tick input.
- R4: When clk_sel bit 2 is 1, the reload is the 17-bit value {clk_sel[1], reload_q}. Otherwise it is the 16-bit reload_q.
- R5: The first flag after enabling comes on the (full+1)th selected tick after the enable write. The first tick loads the counter.
- R6: wr_ready is 1 while idle. It falls on the first selected tick that sees enable set, and it rises on the first selected tick that sees enable clear.
- R7: A reload write (reload_we) updates reload_q one cycle later only while wr_ready is 1. Otherwise the write is ignored.
- R8: wake_flag stays set until flag_clr is pulsed. If an expiry and a clear happen in the same cycle, the flag is set.
- R9: wake_irq equals wake_flag AND the interrupt-enable bit.
- R10: When enabled with clk_sel = 011 and reload_q = 0, cfg_fault is 1. In that state the counter and wr_ready do not change and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | Slow tick pulse, synchronous to clk |
| ctrl_we | input | 1 | Write strobe for the control fields |
| ctrl_enable | input | 1 | Counter enable to write |
| ctrl_irq_en | input | 1 | Interrupt enable to write |
| ctrl_clk_sel | input | 3 | Clock-select code to write |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_wdata | input | 16 | Reload value to write |
| flag_clr | input | 1 | Clears the wakeup flag |
| reload_q | output | 16 | Current reload value |
| wr_ready | output | 1 | Reload register is writable |
| wake_flag | output | 1 | Sticky wakeup flag |
| wake_irq | output | 1 | Wakeup interrupt |
| cfg_fault | output | 1 | Forbidden setting is active |

## Verification
A wrong count state shows up as a flag interval that differs from (full+1) divider periods. This is visible at the second flag, and for a bad load at the first flag after enabling. A wrong prescaler tap changes the interval by a whole power-of-two factor, so it shows within one period. A wrong busy state shows up at wr_ready one tick after the enable edge, and a write that leaks through shows at reload_q on the next cycle. A fault that fails to freeze the counter produces a flag within one short window.

// File: rtl/wkt_pkg.sv
// Package: shared control-field type for the wakeup timer.
// Assumes the clock-select code is always three bits wide.
package wkt_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_FASTEST = 3'b011;

    typedef struct packed {
        logic             enable;
        logic             irq_en;
        logic [SEL_W-1:0] clk_sel;
    } wkt_ctrl_t;
endpackage

// File: rtl/wkt_prescaler.sv
// Module: wkt_prescaler
// Derives the counting tick. Codes with bit 2 clear pick a tap of a
// free-running counter: code c ticks once every 2**(DIV_W-c) cycles.
// Codes with bit 2 set pass sec_tick through.
// Assumes DIV_W >= 4 so that every two-bit code has its own tap.
module wkt_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       sec_tick,
    output logic       tick
);
    logic [DIV_W-1:0] div_cnt;
    logic [3:0]       taps;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    // One tap per code: all low bits of the counter set.
    for (genvar k = 0; k < 4; k++) begin : g_tap
        assign taps[k] = &div_cnt[DIV_W-1-k:0];
    end

    // Pick the tap, or the slow tick for codes 1xx.
    always_comb begin
        tick = clk_sel[2] ? sec_tick : taps[clk_sel[1:0]];
    end
endmodule

// File: rtl/wkt_counter.sv
// Module: wkt_counter
// Auto-reload down-counter. The first tick after enabling loads
// full-1 (or raises an expiry when full is 0). Each later tick
// decrements the count, and a tick at zero raises an expiry and
// reloads full. The busy state drives wr_ready.
// Assumes reload and clk_sel are stable while busy.
module wkt_counter #(
    parameter int RELOAD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [2:0]          clk_sel,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                tick,
    output logic                expire,
    output logic                wr_ready,
    output logic                cfg_fault
);
    import wkt_pkg::*;
    localparam int CNT_W = RELOAD_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] full;
    logic             busy;
    logic             step;

    // Effective reload; the 17-bit mode borrows clk_sel[1] as the top bit.
    always_comb begin
        full      = {clk_sel[2] & clk_sel[1], reload};
        cfg_fault = enable && (clk_sel == SEL_FASTEST) && (reload == '0);
        step      = tick && !cfg_fault;
        expire    = step && enable &&
                    ((!busy && full == '0) || (busy && cnt == '0));
        wr_ready  = !busy;
    end

    // Busy follows enable, but only on a counting tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy <= 1'b0;
        else if (step) busy <= enable;
    end

    // Load on the first tick, then count down and reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step && enable) begin
            if (!busy)           cnt <= (full == '0) ? '0 : full - 1'b1;
            else if (cnt == '0)  cnt <= full;
            else                 cnt <= cnt - 1'b1;
        end
    end

    AST_RELOAD_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == $past(full)));                            // R2
    AST_READY_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick));                                // R6
    AST_FAULT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fault |=> ($stable(cnt) && $stable(busy)));              // R10
endmodule

// File: rtl/wkt_regs.sv
// Module: wkt_regs
// Holds the control fields, the guarded reload value and the sticky
// flag, and forms the interrupt.
// Assumes expire is a single-cycle pulse from the counter.
module wkt_regs #(
    parameter int RELOAD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  wkt_pkg::wkt_ctrl_t   ctrl_wdata,
    input  logic                 reload_we,
    input  logic [RELOAD_W-1:0]  reload_wdata,
    input  logic                 flag_clr,
    input  logic                 expire,
    input  logic                 wr_ready,
    output wkt_pkg::wkt_ctrl_t   ctrl_q,
    output logic [RELOAD_W-1:0]  reload_q,
    output logic                 wake_flag,
    output logic                 wake_irq
);
    // Control fields, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Reload value; writes count only while ready.
    always_ff @(posedge clk) begin
        if (!rst_n)                     reload_q <= '1;
        else if (reload_we && wr_ready) reload_q <= reload_wdata;
    end

    // Sticky flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        wake_flag <= 1'b0;
        else if (expire)   wake_flag <= 1'b1;
        else if (flag_clr) wake_flag <= 1'b0;
    end

    // Interrupt gated by its enable.
    always_comb begin
        wake_irq = wake_flag & ctrl_q.irq_en;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !flag_clr) |=> wake_flag);                     // R8
    AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> $stable(reload_q));                            // R7
endmodule

// File: rtl/wakeup_timer.sv
// Module: wakeup_timer
// Top of the periodic wakeup timer: prescaler, counter and registers.
// Assumes sec_tick is a single-cycle pulse synchronous to clk.
module wakeup_timer #(
    parameter int RELOAD_W = 16,
    parameter int DIV_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic                ctrl_we,
    input  logic                ctrl_enable,
    input  logic                ctrl_irq_en,
    input  logic [2:0]          ctrl_clk_sel,
    input  logic                reload_we,
    input  logic [RELOAD_W-1:0] reload_wdata,
    input  logic                flag_clr,
    output logic [RELOAD_W-1:0] reload_q,
    output logic                wr_ready,
    output logic                wake_flag,
    output logic                wake_irq,
    output logic                cfg_fault
);
    import wkt_pkg::*;

    wkt_ctrl_t ctrl_wdata;
    wkt_ctrl_t ctrl_q;
    logic      tick;
    logic      expire;

    // Pack the control write fields.
    always_comb begin
        ctrl_wdata = '{enable: ctrl_enable, irq_en: ctrl_irq_en, clk_sel: ctrl_clk_sel};
    end

    wkt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clk_sel(ctrl_q.clk_sel),
        .sec_tick(sec_tick), .tick(tick)
    );

    wkt_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_q.enable),
        .clk_sel(ctrl_q.clk_sel), .reload(reload_q), .tick(tick),
        .expire(expire), .wr_ready(wr_ready), .cfg_fault(cfg_fault)
    );

    wkt_regs #(.RELOAD_W(RELOAD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .reload_we(reload_we), .reload_wdata(reload_wdata),
        .flag_clr(flag_clr), .expire(expire), .wr_ready(wr_ready),
        .ctrl_q(ctrl_q), .reload_q(reload_q),
        .wake_flag(wake_flag), .wake_irq(wake_irq)
    );
endmodule

// File: tb/wakeup_timer_tb.sv
module wakeup_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 190000;

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] rl;
        logic [7:0]  sp;     // slow tick spacing in cycles, 0 = none
        logic [31:0] expc;   // expected flag interval in cycles
    } vec_t;

    // R3 / R2 / R4: interval = (full+1) * tick spacing
    localparam vec_t VECS [6] = '{
        '{3'b000, 16'd3, 8'd0, 32'd64},
        '{3'b001, 16'd5, 8'd0, 32'd48},
        '{3'b010, 16'd7, 8'd0, 32'd32},
        '{3'b011, 16'd9, 8'd0, 32'd20},
        '{3'b100, 16'd4, 8'd3, 32'd15},
        '{3'b101, 16'd2, 8'd1, 32'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        ctrl_we = 1'b0, ctrl_enable = 1'b0, ctrl_irq_en = 1'b0;
    logic [2:0]  ctrl_clk_sel = '0;
    logic        reload_we = 1'b0;
    logic [15:0] reload_wdata = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] reload_q;
    logic        wr_ready, wake_flag, wake_irq, cfg_fault;

    int n_tests = 0;
    int n_fail  = 0;
    int sec_per = 0;
    int sec_cnt = 0;

    wakeup_timer dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable), .ctrl_irq_en(ctrl_irq_en),
        .ctrl_clk_sel(ctrl_clk_sel), .reload_we(reload_we),
        .reload_wdata(reload_wdata), .flag_clr(flag_clr),
        .reload_q(reload_q), .wr_ready(wr_ready), .wake_flag(wake_flag),
        .wake_irq(wake_irq), .cfg_fault(cfg_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slow tick source, driven away from the active edge.
    always @(negedge clk) begin
        if (sec_per == 0) begin
            sec_tick = 1'b0;
            sec_cnt  = 0;
        end else if (sec_cnt >= sec_per - 1) begin
            sec_tick = 1'b1;
            sec_cnt  = 0;
        end else begin
            sec_tick = 1'b0;
            sec_cnt  = sec_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic en, input logic ie, input logic [2:0] sel);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_enable = en; ctrl_irq_en = ie; ctrl_clk_sel = sel;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_reload(input logic [15:0] v);
        @(negedge clk);
        reload_we = 1'b1; reload_wdata = v;
        @(negedge clk);
        reload_we = 1'b0;
    endtask

    task automatic clr_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // Count cycles (sampled at negedge) until the flag is seen.
    task automatic wait_flag(output int n);
        n = 0;
        while (!wake_flag && n < 100000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && !wr_ready; i++) @(negedge clk);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reload_q == 16'hFFFF, "R1 reload_q", reload_q, 16'hFFFF);
        chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
        chk(wake_flag == 1'b0 && wake_irq == 1'b0, "R1 flag/irq", wake_flag, 0);
        chk(cfg_fault == 1'b0, "R1 cfg_fault", cfg_fault, 0);

        // Interval per select code (R2, R3, R4)
        foreach (VECS[i]) begin
            sec_per = int'(VECS[i].sp);
            wr_ctrl(1'b0, 1'b0, VECS[i].sel);
            wait_ready();
            wr_reload(VECS[i].rl);
            chk(reload_q == VECS[i].rl, "R7 write while ready", reload_q, VECS[i].rl);
            clr_flag();
            wr_ctrl(1'b1, 1'b0, VECS[i].sel);
            wait_flag(n);
            chk(wake_irq == 1'b0, "R9 irq masked", wake_irq, 0);
            // clear and time the next expiry
            flag_clr = 1'b1;
            @(negedge clk);
            flag_clr = 1'b0;
            n = 1;
            while (!wake_flag && n < 100000) begin
                @(negedge clk);
                n++;
            end
            chk(n == int'(VECS[i].expc), "R2 R3 R4 interval", n, int'(VECS[i].expc));
        end

        // R5 / R6 / R7: first flag timing, ready handshake, locked write
        sec_per = 1;
        wr_ctrl(1'b0, 1'b1, 3'b100);
        wait_ready();
        wr_reload(16'd4);
        clr_flag();
        wr_ctrl(1'b1, 1'b1, 3'b100);     // captured at e0
        chk(wr_ready == 1'b1, "R6 ready before first tick", wr_ready, 1);
        @(negedge clk);                  // after e1
        chk(wr_ready == 1'b0, "R6 ready falls", wr_ready, 0);
        repeat (3) @(negedge clk);       // after e4
        chk(wake_flag == 1'b0, "R5 no flag at tick 4", wake_flag, 0);
        @(negedge clk);                  // after e5
        chk(wake_flag == 1'b1, "R5 flag at tick 5", wake_flag, 1);
        chk(wake_irq == 1'b1, "R9 irq follows flag", wake_irq, 1);
        repeat (7) @(negedge clk);
        chk(wake_flag == 1'b1, "R8 flag sticky", wake_flag, 1);
        clr_flag();
        chk(wake_irq == 1'b0, "R9 irq drops after clear", wake_irq, 0);
        wr_reload(16'h1234);
        chk(reload_q == 16'd4, "R7 write ignored while busy", reload_q, 4);

        // R6: ready returns on the first tick after disable
        wr_ctrl(1'b0, 1'b1, 3'b100);
        @(negedge clk);
        chk(wr_ready == 1'b1, "R6 ready returns", wr_ready, 1);

        // R4 / R5: 17-bit mode, clk_sel[1] supplies bit 16
        wr_reload(16'd2);
        clr_flag();
        wr_ctrl(1'b1, 1'b0, 3'b110);
        wait_flag(n);
        chk(n == 65539, "R4 17-bit first flag", n, 65539);
        wr_ctrl(1'b0, 1'b0, 3'b110);
        wait_ready();
        clr_flag();

        // R10: forbidden setting freezes the counter
        sec_per = 0;
        wr_ctrl(1'b0, 1'b0, 3'b011);
        wait_ready();
        wr_reload(16'd0);
        wr_ctrl(1'b1, 1'b0, 3'b011);
        chk(cfg_fault == 1'b1, "R10 fault raised", cfg_fault, 1);
        repeat (100) @(negedge clk);
        chk(wake_flag == 1'b0, "R10 no flag while faulted", wake_flag, 0);
        chk(wr_ready == 1'b1, "R10 ready held", wr_ready, 1);
        wr_ctrl(1'b0, 1'b0, 3'b011);
        chk(cfg_fault == 1'b0, "R10 fault clears on disable", cfg_fault, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule